// File: doc/BRIEF.md
# PWM Duty-Cycle to Code Converter

This block turns one pulse-width-modulated input into an N-bit code. A fast sampling clock is used to count the high time of each PWM cycle and the interval between successive rising edges. At every rising edge, the block takes the cycle that has just finished and divides its high time by its period. It then presents the scaled ratio `2^N * high / period` together with a one-cycle valid strobe. The strobe appears a fixed number of clock cycles after the edge, whether or not the divider could have finished sooner.

Some edges do not lead to a normal result. If the cycle was shorter than the computation window, the code is not updated. The same holds when the edges are further apart than the idle timeout, and for the very first edge after reset. In the first two cases a skipped-update strobe fires instead. A high pulse narrower than a minimum width forces the result to zero. A low pulse narrower than its minimum width forces the result to full-scale. Choosing what an idle output should show is left to the consumer of this block.

Top module: `pwm_code_conv`

## Requirements
- R1: During and directly after reset, `code_o` is 0 and both `valid_o` and `skip_o` are low.
- R2: For an accepted edge, the new code is floor(2^CODE_W * H / P). H is the number of sampling-clock cycles the input was high between the previous rising edge and this one. P is the number of cycles between the two rising edges.
- R3: For an accepted edge, `valid_o` is high for exactly one cycle. That cycle follows the (SYNC_STAGES+LAT_CYC)-th rising clock edge, counting the first edge that samples the input high as edge 1. `valid_o` is low in the cycle before it.
- R4: If H < MIN_HIGH on an accepted edge, the code is 0.
- R5: If H >= MIN_HIGH and P-H < MIN_LOW on an accepted edge, the code is 2^CODE_W-1.
- R6: An edge with P < LAT_CYC gives no valid strobe, and `code_o` keeps its previous value.
- R7: An edge with P > TIMEOUT_CYC gives no valid strobe, and `code_o` keeps its value. An edge with P equal to TIMEOUT_CYC is accepted.
- R8: The period counter saturates at 2^CNT_W-1 and does not wrap. A gap longer than the counter range is therefore still treated as a timeout.
- R9: The first rising edge after reset produces neither a valid strobe nor a skip strobe.
- R10: Every rejected edge other than the first raises `skip_o` for one cycle, following the (SYNC_STAGES+1)-th clock edge counted as in R3. An accepted edge leaves `skip_o` low in that cycle.
- R11: `code_o` changes only in a cycle where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Asynchronous PWM input |
| code_o | output | CODE_W | Last computed duty code |
| valid_o | output | 1 | One-cycle strobe marking a new code |
| skip_o | output | 1 | One-cycle strobe marking an edge that gave no update |

## Verification
Several properties are checked on every cycle by assertions:
- the valid strobe is a single cycle wide;
- the code is stable outside a strobe;
- a skip only follows a detected edge;
- the saturated period counter holds its value;
- the divider remainder stays below the divisor;
- the divider is idle once the latency window closes.

The arithmetic itself can only be shown by the bench's scenarios. It sweeps every high/low split of every period from 2 to 40 cycles in a 4-bit configuration. Those scenarios also cover the exact strobe cycle, the narrow-pulse forcing, the timeout edge at and just past its limit, and a gap longer than the counter range.

// File: rtl/pwm_conv_pkg.sv
package pwm_conv_pkg;

   // Override applied to the divider result for an accepted edge.
   typedef enum logic [1:0] {
      FORCE_NONE = 2'd0,
      FORCE_ZERO = 2'd1,
      FORCE_FULL = 2'd2
   } force_e;

   // Bits needed to hold the value v.
   function automatic int unsigned bits_for(input int unsigned v);
      return $clog2(v + 1);
   endfunction

endpackage

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_i,
   output logic lvl_o,
   output logic rise_o
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("pwm_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   // Stages 0..STAGES-1 form the synchronizer; stage STAGES keeps the
   // previous synchronized level for edge detection.
   generate
      for (genvar g = 0; g <= STAGES; g++) begin : g_stage
         logic q;
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= 1'b0;
               else        q <= pwm_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= 1'b0;
               else        q <= g_stage[g-1].q;
            end
         end
      end
   endgenerate

   assign lvl_o  = g_stage[STAGES-1].q;
   assign rise_o = g_stage[STAGES-1].q & ~g_stage[STAGES].q;

endmodule

// File: rtl/pwm_meter.sv
module pwm_meter #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned MIN_HIGH = 3,
   parameter int unsigned MIN_LOW  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_i,
   input  logic             rise_i,
   output logic [CNT_W-1:0] per_o,
   output logic [CNT_W-1:0] hi_o,
   output logic             seen_o,
   output logic             narrow_hi_o,
   output logic             narrow_lo_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (MIN_HIGH >= (1 << CNT_W) || MIN_LOW >= (1 << CNT_W)) begin : g_bad
         $error("pwm_meter: minimum pulse widths exceed counter range");
      end
   endgenerate

   logic [CNT_W-1:0] per_cnt;
   logic [CNT_W-1:0] hi_cnt;
   logic             seen_q;
   logic [CNT_W-1:0] lo_len;

   // Cycles since the last rising edge, saturating at the counter maximum.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                per_cnt <= '0;
      else if (rise_i)           per_cnt <= CNT_W'(1);
      else if (per_cnt != CNT_MAX) per_cnt <= per_cnt + CNT_W'(1);
   end

   // Cycles spent high since the last rising edge (the edge cycle is high).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          hi_cnt <= '0;
      else if (rise_i)                     hi_cnt <= CNT_W'(1);
      else if (lvl_i && hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seen_q <= 1'b0;
      else if (rise_i) seen_q <= 1'b1;
   end

   assign per_o       = per_cnt;
   assign hi_o        = hi_cnt;
   assign seen_o      = seen_q;
   assign lo_len      = per_cnt - hi_cnt;
   assign narrow_hi_o = hi_cnt < CNT_W'(MIN_HIGH);
   assign narrow_lo_o = lo_len < CNT_W'(MIN_LOW);

   assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise_i && per_cnt == CNT_MAX) |=> (per_cnt == CNT_MAX));

   assert_hi_within_per_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hi_cnt <= per_cnt);

endmodule

// File: rtl/pwm_ratio_div.sv
module pwm_ratio_div #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  num_i,
   input  logic [CNT_W-1:0]  den_i,
   output logic              busy_o,
   output logic [CODE_W-1:0] quot_o
);

   localparam int unsigned STEP_W = pwm_conv_pkg::bits_for(CODE_W);
   localparam int unsigned REM_W  = CNT_W + 1;

   logic [REM_W-1:0]  rem_q;
   logic [REM_W-1:0]  rem_dbl;
   logic [REM_W-1:0]  den_q;
   logic [CODE_W-1:0] q_q;
   logic [STEP_W-1:0] step_q;
   logic              busy_q;
   logic              ovf_q;
   logic              fits;

   // Restoring division of num*2^CODE_W by den, one quotient bit per cycle.
   // Numerator below the divisor keeps every partial remainder under den.
   assign rem_dbl = {rem_q[REM_W-2:0], 1'b0};
   assign fits    = rem_dbl >= den_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         den_q  <= '0;
         q_q    <= '0;
         step_q <= '0;
         busy_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else if (start_i) begin
         ovf_q  <= num_i >= den_i;
         rem_q  <= (num_i >= den_i) ? '0 : {1'b0, num_i};
         den_q  <= {1'b0, den_i};
         q_q    <= '0;
         step_q <= STEP_W'(CODE_W);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         rem_q  <= fits ? (rem_dbl - den_q) : rem_dbl;
         q_q    <= {q_q[CODE_W-2:0], fits};
         step_q <= step_q - STEP_W'(1);
         busy_q <= step_q != STEP_W'(1);
      end
   end

   // A ratio of one or more saturates to full-scale.
   assign quot_o = ovf_q ? {CODE_W{1'b1}} : q_q;
   assign busy_o = busy_q;

   assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (rem_q < den_q));

   assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_q);

endmodule

// File: rtl/pwm_code_conv.sv
module pwm_code_conv #(
   parameter int unsigned CODE_W      = 12,
   parameter int unsigned CNT_W       = 23,
   parameter int unsigned LAT_CYC     = 320,
   parameter int unsigned MIN_HIGH    = 3,
   parameter int unsigned MIN_LOW     = 3,
   parameter int unsigned TIMEOUT_CYC = 6_000_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_i,
   output logic [CODE_W-1:0] code_o,
   output logic              valid_o,
   output logic              skip_o
);

   import pwm_conv_pkg::*;

   localparam int unsigned WAIT_W = bits_for(LAT_CYC);

   generate
      if (CODE_W < 2) begin : g_bad_code
         $error("pwm_code_conv: CODE_W must be at least 2");
      end
      if (LAT_CYC < CODE_W + 2) begin : g_bad_lat
         $error("pwm_code_conv: LAT_CYC too short for the divider");
      end
      if (TIMEOUT_CYC >= (1 << CNT_W) - 1) begin : g_bad_tmo
         $error("pwm_code_conv: TIMEOUT_CYC must lie below counter saturation");
      end
      if (LAT_CYC > TIMEOUT_CYC) begin : g_bad_win
         $error("pwm_code_conv: LAT_CYC must not exceed TIMEOUT_CYC");
      end
   endgenerate

   logic              lvl;
   logic              rise;
   logic [CNT_W-1:0]  per_len;
   logic [CNT_W-1:0]  hi_len;
   logic              seen;
   logic              narrow_hi;
   logic              narrow_lo;
   logic              in_window;
   logic              accept;
   logic              reject;
   logic              div_busy;
   logic [CODE_W-1:0] div_quot;
   force_e            force_q;
   logic [WAIT_W-1:0] wait_q;
   logic [CODE_W-1:0] next_code;

   pwm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pwm_i (pwm_i),
      .lvl_o (lvl),
      .rise_o(rise)
   );

   pwm_meter #(.CNT_W(CNT_W), .MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW)) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (lvl),
      .rise_i     (rise),
      .per_o      (per_len),
      .hi_o       (hi_len),
      .seen_o     (seen),
      .narrow_hi_o(narrow_hi),
      .narrow_lo_o(narrow_lo)
   );

   // Edge decision: a measurable period that neither undercuts the
   // computation window nor exceeds the idle timeout.
   assign in_window = (per_len >= CNT_W'(LAT_CYC)) && (per_len <= CNT_W'(TIMEOUT_CYC));
   assign accept    = rise && seen && in_window;
   assign reject    = rise && seen && !in_window;

   pwm_ratio_div #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(accept),
      .num_i  (hi_len),
      .den_i  (per_len),
      .busy_o (div_busy),
      .quot_o (div_quot)
   );

   // Narrow-pulse override and fixed-latency release counter.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_q <= FORCE_NONE;
         wait_q  <= '0;
      end else if (accept) begin
         force_q <= narrow_hi ? FORCE_ZERO : (narrow_lo ? FORCE_FULL : FORCE_NONE);
         wait_q  <= WAIT_W'(LAT_CYC - 1);
      end else if (wait_q != '0) begin
         wait_q  <= wait_q - WAIT_W'(1);
      end
   end

   always_comb begin
      case (force_q)
         FORCE_ZERO: next_code = '0;
         FORCE_FULL: next_code = '1;
         default:    next_code = div_quot;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o  <= '0;
         valid_o <= 1'b0;
         skip_o  <= 1'b0;
      end else begin
         valid_o <= wait_q == WAIT_W'(1);
         skip_o  <= reject;
         if (wait_q == WAIT_W'(1)) code_o <= next_code;
      end
   end

   assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   assert_div_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q == WAIT_W'(1)) |-> !div_busy);

   assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(code_o));

   assert_skip_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> $past(rise));

   assert_skip_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |=> !skip_o);

endmodule

// File: tb/pwm_code_conv_bench.sv
`timescale 1ns/1ps
module pwm_code_conv_bench;

   localparam int CODE_W = 4;
   localparam int CNT_W  = 10;
   localparam int LAT    = 8;
   localparam int MINH   = 2;
   localparam int MINL   = 2;
   localparam int TMO    = 300;
   localparam int STG    = 2;
   localparam int CMAX   = (1 << CNT_W) - 1;
   localparam int FULL   = (1 << CODE_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pwm = 1'b0;
   logic [CODE_W-1:0] code;
   logic              valid;
   logic              skip;

   int nvec  = 0;
   int nfail = 0;

   always #5 clk = ~clk;

   pwm_code_conv #(
      .CODE_W(CODE_W), .CNT_W(CNT_W), .LAT_CYC(LAT), .MIN_HIGH(MINH),
      .MIN_LOW(MINL), .TIMEOUT_CYC(TMO), .SYNC_STAGES(STG)
   ) u_pwm_code_conv (
      .clk(clk), .rst_n(rst_n), .pwm_i(pwm),
      .code_o(code), .valid_o(valid), .skip_o(skip)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Prime edge after a low gap, then h high cycles, lo low cycles, then the
   // measured edge; checks the strobes and the code against the arithmetic.
   task automatic run_vec(input int h, input int lo, input int gap);
      int p;
      bit acc;
      int exp;
      string tag;
      int prev;
      p   = h + lo;
      acc = (p >= LAT) && (p <= TMO);
      if (h < MINH)       exp = 0;
      else if (lo < MINL) exp = FULL;
      else                exp = (h * (1 << CODE_W)) / p;
      if (exp > FULL) exp = FULL;
      if (acc) tag = (h < MINH) ? "R4" : ((lo < MINL) ? "R5" : "R2");
      else     tag = (p < LAT) ? "R6" : ((p > CMAX) ? "R8" : "R7");
      prev = 0;
      repeat (gap) @(negedge clk);
      pwm = 1'b1;
      repeat (h) @(negedge clk);
      pwm = 1'b0;
      repeat (lo) @(negedge clk);
      pwm = 1'b1;
      for (int k = 1; k <= STG + LAT; k++) begin
         @(negedge clk);
         if (k == STG + 1)
            check(skip == !acc, acc ? "R10 skip low on accept" : {"R10 skip ", tag},
                  int'(skip), int'(!acc));
         if (k == STG + LAT - 1) begin
            check(valid == 1'b0, "R3 no early valid", int'(valid), 0);
            prev = int'(code);
         end
         if (k == STG + LAT) begin
            if (acc) begin
               check(valid == 1'b1, "R3 valid strobe", int'(valid), 1);
               check(int'(code) == exp, tag, int'(code), exp);
            end else begin
               check(valid == 1'b0, tag, int'(valid), 0);
               check(int'(code) == prev, "R11 code held", int'(code), prev);
            end
         end
      end
      pwm = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(code == '0, "R1 code", int'(code), 0);
      check(valid == 1'b0, "R1 valid", int'(valid), 0);
      check(skip == 1'b0, "R1 skip", int'(skip), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R9: the first edge after reset gives neither strobe.
      pwm = 1'b1;
      for (int k = 1; k <= STG + LAT + 2; k++) begin
         @(negedge clk);
         check(valid == 1'b0, "R9 valid", int'(valid), 0);
         check(skip == 1'b0, "R9 skip", int'(skip), 0);
      end
      pwm = 1'b0;
      // Exhaustive sweep: every split of every period 2..40 (R2 R4 R5 R6).
      for (int p = 2; p <= 40; p++)
         for (int h = 1; h < p; h++)
            run_vec(h, p - h, 4);
      // R7: timeout boundary.
      run_vec(150, 150, 4);
      run_vec(150, 151, 4);
      // R8: gap beyond counter range must not wrap into acceptance.
      run_vec(10, 1200, 4);
      // Recovery after a timed-out prime edge.
      run_vec(5, 5, 400);
      run_vec(3, 9, 4);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      #2_000_000;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule